// File: doc/BRIEF.md
# I/O Register-Space Decoder with Program-Memory Page Extension

This block sits beside the CPU of a small 8-bit microcontroller and decodes register-space accesses. An access can arrive on one of two paths. The short I/O path serves the dedicated in/out instructions and carries a 6-bit offset. The data-space path serves the load/store instructions and carries a full 16-bit data address. Both paths reach the same bank of I/O registers. The data-space path sees that bank shifted up by 0x20. It can also reach an extended register area that starts at data address 0x60, which the short path has no way to address. For every register it decodes, the block raises one select line, together with the access strobe and the write data.

The block owns one register itself: an 8-bit program-memory page register. Only the lowest `PAGE_BITS` bits of it are implemented. The block joins this page with the 16-bit Z pointer to form the long program-memory address used by the extended load and self-programming instructions. The plain program-memory load uses the Z pointer alone.

Top module: `io_space_decoder`

## Requirements
- R1: A read or write strobe on the short I/O path at offset `o` (0x00 to 0x3F, except 0x1B) raises select line `o` only. It also forwards the strobe on `acc_rd`/`acc_wr` and the write byte on `acc_wdata`, in the same cycle.
- R2: A data-space strobe at address `a`, with 0x20 <= a <= 0x5F and a != 0x3B, raises select line `a - 0x20`. This is the same line the short path raises for that register.
- R3: A data-space strobe at address `a`, with 0x60 <= a <= `EXT_LAST`, raises select line `64 + (a - 0x60)`. This extended area is reachable only through data space.
- R4: A data-space strobe below 0x20 or above `EXT_LAST` raises no select line and no forwarded strobe. It also does not touch the page register.
- R5: The page register answers at I/O offset 0x1B and at data address 0x3B. A write on either path updates it at the next rising clock edge. A read returns its value on `rd_data` in the same cycle. An access to it raises no select line and no forwarded strobe. Without such a write it keeps its value.
- R6: Only page bits [PAGE_BITS-1:0] are stored. The upper bits always read as zero, and any data written to them is discarded.
- R7: A synchronous active-low reset clears the page register to zero.
- R8: When `pm_op` is 2'b01 (extended load) or 2'b10 (self-program), `long_addr` is {page[PAGE_BITS-1:0], z_hi, z_lo}.
- R9: When `pm_op` is 2'b00 (plain load) or 2'b11 (treated as plain load), `long_addr` is {zeros, z_hi, z_lo}, whatever the page holds.
- R10: At most one select line is high in any cycle. When both paths strobe in the same cycle, the short I/O path is served and the data-space access is ignored.
- R11: `rd_data` is 0x00 whenever there is no read of the page register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 6 | Short I/O path offset |
| io_rd | input | 1 | Short path read strobe |
| io_wr | input | 1 | Short path write strobe |
| io_wdata | input | 8 | Short path write byte |
| ds_addr | input | 16 | Data-space address |
| ds_rd | input | 1 | Data-space read strobe |
| ds_wr | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write byte |
| z_hi | input | 8 | Z pointer high byte |
| z_lo | input | 8 | Z pointer low byte |
| pm_op | input | 2 | Program-memory instruction type |
| sel | output | NSEL | One select line per decoded register (64 + EXT_LAST - 0x5F) |
| acc_rd | output | 1 | Forwarded read strobe for the selected register |
| acc_wr | output | 1 | Forwarded write strobe for the selected register |
| acc_wdata | output | 8 | Forwarded write byte |
| rd_data | output | 8 | Page register read data, zero otherwise |
| long_addr | output | 16+PAGE_BITS | Long program-memory address |

## Verification
Several properties are checked on every cycle:
- the page register takes the masked write byte from either path, and holds its value otherwise;
- its upper bits stay zero;
- select lines are never more than one-hot, and the short path wins when both paths strobe;
- out-of-range data addresses raise nothing;
- the long address takes its form from the instruction type.

The bench scenarios are needed for the address arithmetic itself, that is, which select index each alias and extended address lands on and the boundary addresses 0x1F, 0x20, 0x5F, 0x60, `EXT_LAST` and one past it. They are also needed to show reset clearing the page mid-run.

// File: rtl/io_dec_pkg.sv
// Package io_dec_pkg
// Shared constants, the program-memory instruction encoding and the access
// record passed between the address map and the top of the decoder.
// Assumes an 8-bit data bus and a 6-bit short I/O offset.
package io_dec_pkg;

    localparam int          IO_SPAN     = 64;
    localparam logic [15:0] DS_IO_BASE  = 16'h0020;
    localparam logic [15:0] DS_EXT_BASE = 16'h0060;
    localparam logic [5:0]  PAGE_IO_OFS = 6'h1B;
    localparam logic [15:0] PAGE_DS_ADR = 16'h003B;

    typedef enum logic [1:0] {
        PM_LOAD      = 2'b00,
        PM_LOAD_EXT  = 2'b01,
        PM_SELF_PROG = 2'b10,
        PM_RSVD      = 2'b11
    } pm_op_e;

    typedef struct packed {
        logic       hit;
        logic       rd;
        logic       wr;
        logic [7:0] wdata;
    } acc_t;

    // True for the instruction types whose long address carries the page.
    function automatic logic op_uses_page(pm_op_e op);
        return (op == PM_LOAD_EXT) || (op == PM_SELF_PROG);
    endfunction

endpackage

// File: rtl/io_addr_map.sv
// Module io_addr_map
// Merges the short I/O path and the data-space path into one access record
// and a unified register index: I/O offsets map to 0..63, extended data
// addresses map from 64 upward. Purely combinational.
// Assumes the CPU drives one path at a time; if both strobe, the short path wins.
module io_addr_map
    import io_dec_pkg::*;
#(
    parameter logic [15:0] EXT_LAST = 16'h00FF,
    parameter int          IDX_W    = 8
) (
    input  logic [5:0]       io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    input  logic [15:0]      ds_addr,
    input  logic             ds_rd,
    input  logic             ds_wr,
    input  logic [7:0]       ds_wdata,
    output acc_t             acc,
    output logic [IDX_W-1:0] idx
);

    logic io_act;
    logic ds_act;
    logic ds_in_io;
    logic ds_in_ext;

    // Classify the data-space address into the aliased or extended window.
    always_comb begin
        io_act    = io_rd | io_wr;
        ds_act    = ds_rd | ds_wr;
        ds_in_io  = (ds_addr >= DS_IO_BASE) && (ds_addr < DS_EXT_BASE);
        ds_in_ext = (ds_addr >= DS_EXT_BASE) && (ds_addr <= EXT_LAST);
    end

    // Pick the served path and translate its address to a register index.
    always_comb begin
        acc = '0;
        idx = '0;
        if (io_act) begin
            acc.hit   = 1'b1;
            acc.rd    = io_rd;
            acc.wr    = io_wr;
            acc.wdata = io_wdata;
            idx       = IDX_W'(io_addr);
        end else if (ds_act && (ds_in_io || ds_in_ext)) begin
            acc.hit   = 1'b1;
            acc.rd    = ds_rd;
            acc.wr    = ds_wr;
            acc.wdata = ds_wdata;
            if (ds_in_io)
                idx = IDX_W'(ds_addr - DS_IO_BASE);
            else
                idx = IDX_W'(ds_addr - DS_EXT_BASE + 16'(IO_SPAN));
        end
    end

endmodule

// File: rtl/page_reg.sv
// Module page_reg
// Program-memory page register with PAGE_BITS implemented bits, presented
// as a zero-extended byte. Synchronous active-low reset to zero.
// Assumes the caller already decoded the write enable.
module page_reg #(
    parameter int PAGE_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wdata,
    output logic [PAGE_BITS-1:0] page,
    output logic [7:0]           page_byte
);

    logic [PAGE_BITS-1:0] q;

    // Store the implemented bits on a decoded write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wdata;
    end

    assign page = q;

    // Widen to a byte; unimplemented bits are tied to zero.
    generate
        if (PAGE_BITS >= 8) begin : g_full
            assign page_byte = q[7:0];
        end else begin : g_part
            assign page_byte = {{(8 - PAGE_BITS){1'b0}}, q};
        end
    endgenerate

    p_reset_zero_r7: assert property (@(posedge clk)
        !rst_n |=> (page_byte == 8'h00));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(page_byte));

    p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (page_byte >> PAGE_BITS) == 8'h00);

endmodule

// File: rtl/long_addr_mux.sv
// Module long_addr_mux
// Forms the long program-memory address from page and Z pointer. The page
// is prefixed only for the extended load and self-program types.
// Combinational; assumes pm_op is stable while the address is consumed.
module long_addr_mux
    import io_dec_pkg::*;
#(
    parameter int PAGE_BITS = 6,
    parameter int LA_W      = 16 + PAGE_BITS
) (
    input  pm_op_e               op,
    input  logic [7:0]           z_hi,
    input  logic [7:0]           z_lo,
    input  logic [PAGE_BITS-1:0] page,
    output logic [LA_W-1:0]      long_addr
);

    // Concatenate the page above Z, or zero it for the plain load.
    always_comb begin
        if (op_uses_page(op))
            long_addr = {page, z_hi, z_lo};
        else
            long_addr = {{PAGE_BITS{1'b0}}, z_hi, z_lo};
    end

endmodule

// File: rtl/io_space_decoder.sv
// Module io_space_decoder
// Top of the register-space decoder: merges both access paths, raises one
// select line per decoded register, owns the page register and drives the
// long program-memory address. Selects and read data are combinational;
// the page updates on the clock edge. Assumes 1 <= PAGE_BITS <= 8 and
// 16'h0060 <= EXT_LAST.
module io_space_decoder
    import io_dec_pkg::*;
#(
    parameter int          PAGE_BITS = 6,
    parameter logic [15:0] EXT_LAST  = 16'h00FF,
    localparam int         NSEL      = IO_SPAN + int'(EXT_LAST) - int'(DS_EXT_BASE) + 1,
    localparam int         IDX_W     = $clog2(NSEL),
    localparam int         LA_W      = 16 + PAGE_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [5:0]      io_addr,
    input  logic            io_rd,
    input  logic            io_wr,
    input  logic [7:0]      io_wdata,
    input  logic [15:0]     ds_addr,
    input  logic            ds_rd,
    input  logic            ds_wr,
    input  logic [7:0]      ds_wdata,
    input  logic [7:0]      z_hi,
    input  logic [7:0]      z_lo,
    input  logic [1:0]      pm_op,
    output logic [NSEL-1:0] sel,
    output logic            acc_rd,
    output logic            acc_wr,
    output logic [7:0]      acc_wdata,
    output logic [7:0]      rd_data,
    output logic [LA_W-1:0] long_addr
);

    localparam int          PAGE_IDX  = int'(PAGE_IO_OFS);
    localparam logic [7:0]  PAGE_MASK = 8'((9'd1 << PAGE_BITS) - 9'd1);

    acc_t                 acc;
    logic [IDX_W-1:0]     idx;
    logic                 page_hit;
    logic [PAGE_BITS-1:0] page;
    logic [7:0]           page_byte;

    io_addr_map #(
        .EXT_LAST (EXT_LAST),
        .IDX_W    (IDX_W)
    ) u_map (
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .ds_addr  (ds_addr),
        .ds_rd    (ds_rd),
        .ds_wr    (ds_wr),
        .ds_wdata (ds_wdata),
        .acc      (acc),
        .idx      (idx)
    );

    // Flag an access that lands on the page register itself.
    always_comb begin
        page_hit = acc.hit && (idx == IDX_W'(PAGE_IDX));
    end

    page_reg #(
        .PAGE_BITS (PAGE_BITS)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (page_hit && acc.wr),
        .wdata     (acc.wdata[PAGE_BITS-1:0]),
        .page      (page),
        .page_byte (page_byte)
    );

    // One select line per register index; the page slot stays low.
    generate
        for (genvar i = 0; i < NSEL; i++) begin : g_sel
            if (i == PAGE_IDX) begin : g_page_slot
                assign sel[i] = 1'b0;
            end else begin : g_reg_slot
                assign sel[i] = acc.hit && (idx == IDX_W'(i));
            end
        end
    endgenerate

    // Forward strobes for external registers, return page data on its reads.
    always_comb begin
        acc_rd    = acc.hit && acc.rd && !page_hit;
        acc_wr    = acc.hit && acc.wr && !page_hit;
        acc_wdata = acc.wdata;
        rd_data   = (page_hit && acc.rd) ? page_byte : 8'h00;
    end

    long_addr_mux #(
        .PAGE_BITS (PAGE_BITS),
        .LA_W      (LA_W)
    ) u_long (
        .op        (pm_op_e'(pm_op)),
        .z_hi      (z_hi),
        .z_lo      (z_lo),
        .page      (page),
        .long_addr (long_addr)
    );

    p_page_io_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == PAGE_IO_OFS) |=> (page_byte == (PAGE_MASK & $past(io_wdata))));

    p_page_ds_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_wr && !io_rd && !io_wr && ds_addr == PAGE_DS_ADR)
            |=> (page_byte == (PAGE_MASK & $past(ds_wdata))));

    p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_io_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && io_addr != PAGE_IO_OFS)
            |-> (sel[io_addr] && $countones(sel) == 1));

    p_out_of_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd && !io_wr && (ds_addr < DS_IO_BASE || ds_addr > EXT_LAST))
            |-> (sel == '0 && !acc_rd && !acc_wr && rd_data == 8'h00));

    p_long_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_op == 2'b01 || pm_op == 2'b10)
            |-> (long_addr == {page_byte[PAGE_BITS-1:0], z_hi, z_lo}));

    p_long_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_op == 2'b00 || pm_op == 2'b11)
            |-> (long_addr == LA_W'({z_hi, z_lo})));

    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd && !ds_rd) |-> (rd_data == 8'h00));

endmodule

// File: tb/io_space_decoder_test.sv
`timescale 1ns/1ps
module io_space_decoder_test;

    localparam int          PAGE_BITS = 6;
    localparam logic [15:0] EXT_LAST  = 16'h00FF;
    localparam int          NSEL      = 64 + int'(EXT_LAST) - 'h60 + 1;
    localparam int          LA_W      = 16 + PAGE_BITS;
    localparam logic [7:0]  MASK      = 8'h3F;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [5:0]      io_addr = '0;
    logic            io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]      io_wdata = '0;
    logic [15:0]     ds_addr = '0;
    logic            ds_rd = 1'b0, ds_wr = 1'b0;
    logic [7:0]      ds_wdata = '0;
    logic [7:0]      z_hi = '0, z_lo = '0;
    logic [1:0]      pm_op = '0;
    logic [NSEL-1:0] sel;
    logic            acc_rd, acc_wr;
    logic [7:0]      acc_wdata, rd_data;
    logic [LA_W-1:0] long_addr;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    io_space_decoder #(.PAGE_BITS(PAGE_BITS), .EXT_LAST(EXT_LAST)) uut (
        .clk(clk), .rst_n(rst_n),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .ds_addr(ds_addr), .ds_rd(ds_rd), .ds_wr(ds_wr), .ds_wdata(ds_wdata),
        .z_hi(z_hi), .z_lo(z_lo), .pm_op(pm_op),
        .sel(sel), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .long_addr(long_addr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_sel(string tag, int exp_idx);
        logic [NSEL-1:0] e;
        e = '0;
        if (exp_idx >= 0) e[exp_idx] = 1'b1;
        tests++;
        if (sel !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, sel, e);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        io_rd = 0; io_wr = 0; ds_rd = 0; ds_wr = 0;
    endtask

    task automatic io_read_page(output logic [7:0] v);
        @(negedge clk);
        ds_rd = 0; ds_wr = 0; io_wr = 0;
        io_addr = 6'h1B; io_rd = 1; #1;
        v = rd_data;
        idle();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        io_read_page(v);
        chk("R7 page after reset", 32'(v), 32'h00);
        chk_sel("R11 idle sel", -1);
        chk("R11 idle rd_data", 32'(rd_data), 32'h00);
    endtask

    task automatic t_io_path();
        int ofs[3] = '{0, 5, 63};
        foreach (ofs[k]) begin
            @(negedge clk);
            io_addr = 6'(ofs[k]); io_rd = 1; #1;
            chk_sel("R1 io read select", ofs[k]);
            chk("R1 io acc_rd", 32'(acc_rd), 32'h1);
            idle();
        end
        @(negedge clk);
        io_addr = 6'h10; io_wr = 1; io_wdata = 8'h5A; #1;
        chk_sel("R1 io write select", 16);
        chk("R1 io acc_wr", 32'(acc_wr), 32'h1);
        chk("R1 io acc_wdata", 32'(acc_wdata), 32'h5A);
        idle();
    endtask

    task automatic t_ds_alias();
        int adr[3] = '{'h20, 'h45, 'h5F};
        foreach (adr[k]) begin
            @(negedge clk);
            ds_addr = 16'(adr[k]); ds_rd = 1; #1;
            chk_sel("R2 data alias select", adr[k] - 'h20);
            chk("R2 data acc_rd", 32'(acc_rd), 32'h1);
            idle();
        end
    endtask

    task automatic t_ext();
        int adr[3] = '{'h60, 'h9C, 'hFF};
        foreach (adr[k]) begin
            @(negedge clk);
            ds_addr = 16'(adr[k]); ds_wr = 1; ds_wdata = 8'hC3; #1;
            chk_sel("R3 extended select", 64 + adr[k] - 'h60);
            chk("R3 extended acc_wr", 32'(acc_wr), 32'h1);
            idle();
        end
    endtask

    task automatic t_out_of_range();
        logic [7:0] v;
        int adr[3] = '{'h00, 'h1F, 'h100};
        foreach (adr[k]) begin
            @(negedge clk);
            ds_addr = 16'(adr[k]); ds_wr = 1; ds_wdata = 8'h2A; #1;
            chk_sel("R4 out of range no select", -1);
            chk("R4 out of range no strobe", 32'({acc_rd, acc_wr}), 32'h0);
            idle();
        end
        io_read_page(v);
        chk("R4 page untouched", 32'(v), 32'h00);
    endtask

    task automatic t_page();
        logic [7:0] v;
        @(negedge clk);
        io_addr = 6'h1B; io_wr = 1; io_wdata = 8'hA5; #1;
        chk_sel("R5 page access raises no select", -1);
        chk("R5 page access no acc_wr", 32'(acc_wr), 32'h0);
        idle();
        @(negedge clk);
        ds_addr = 16'h003B; ds_rd = 1; #1;
        chk("R5 read via data space", 32'(rd_data), 32'(8'hA5 & MASK));
        chk("R5 page read no acc_rd", 32'(acc_rd), 32'h0);
        idle();
        @(negedge clk);
        ds_addr = 16'h003B; ds_wr = 1; ds_wdata = 8'hFF;
        idle();
        io_read_page(v);
        chk("R6 upper bits read zero", 32'(v), 32'(MASK));
        @(negedge clk);
        io_addr = 6'h1A; io_wr = 1; io_wdata = 8'h00;
        idle();
        io_read_page(v);
        chk("R5 other write keeps page", 32'(v), 32'h3F);
    endtask

    task automatic t_long();
        logic [7:0] v;
        @(negedge clk);
        io_addr = 6'h1B; io_wr = 1; io_wdata = 8'h25;
        idle();
        io_read_page(v);
        z_hi = 8'h12; z_lo = 8'h34;
        pm_op = 2'b01; #1;
        chk("R8 extended load address", 32'(long_addr), {10'h0, 6'h25, 16'h1234});
        pm_op = 2'b10; #1;
        chk("R8 self-program address", 32'(long_addr), {10'h0, 6'h25, 16'h1234});
        pm_op = 2'b00; #1;
        chk("R9 plain load ignores page", 32'(long_addr), 32'h1234);
        pm_op = 2'b11; #1;
        chk("R9 reserved code as plain", 32'(long_addr), 32'h1234);
        pm_op = 2'b00;
    endtask

    task automatic t_priority();
        logic [7:0] v;
        @(negedge clk);
        io_addr = 6'h05; io_rd = 1; ds_addr = 16'h0060; ds_rd = 1; #1;
        chk_sel("R10 short path wins", 5);
        idle();
        @(negedge clk);
        io_addr = 6'h07; io_rd = 1; ds_addr = 16'h003B; ds_wr = 1; ds_wdata = 8'h01;
        idle();
        io_read_page(v);
        chk("R10 ignored data write", 32'(v), 32'h25);
    endtask

    task automatic t_mid_reset();
        logic [7:0] v;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        io_read_page(v);
        chk("R7 reset clears page", 32'(v), 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_io_path();
        t_ds_alias();
        t_ext();
        t_out_of_range();
        t_page();
        t_long();
        t_priority();
        t_mid_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #40000;
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule